// File: doc/BRIEF.md
# Cycle-Stealing Device-to-Memory Block Mover

This block copies a run of words from one device into consecutive memory locations. It shares the memory bus with the processor. Software sets up a base address and a word count through a small register write port. Software then writes a start command, which stands for the read the processor has just issued to the device. From then on the device offers each word with a request line. The engine writes each word to memory without the processor handling any of them.

The engine only writes in a cycle when the processor's bus-busy input is low, so it takes bus cycles the processor would otherwise leave unused. A memory write happens only when three things are true in the same cycle: the bus is free, the device has a word ready, and a transfer is running. When the last word has been written, the engine drops its busy flag and raises a sticky interrupt. The interrupt stays high until software clears it with a control write.

Top module: `dma_steal_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_we` and `dev_ack` are all low.
- R2: A start command with a nonzero count sets `busy` on the next clock edge. The k-th word written (k counting from 0) goes to address base+k, and its data is the value on `dev_data` in that cycle.
- R3: `mem_we` is never high in a cycle where `cpu_bus_busy` is high. Such a cycle leaves the address and the remaining count unchanged.
- R4: In a free bus cycle where `dev_req` is low, the engine writes nothing and keeps its address and count unchanged.
- R5: At the clock edge that completes the final word, `busy` falls and `irq` rises together.
- R6: A start command with a count of zero raises `irq` at the next edge. It writes nothing to memory, and `busy` stays low.
- R7: `irq` stays high until a control write with bit 1 (clear) set. A completion in the same cycle as a clear wins, and `irq` stays high.
- R8: While `busy` is high, a start command is ignored. A write to the base or count register during a transfer changes only the next transfer.
- R9: Register select 0 writes the base address and select 1 writes the word count. Select 2 is the control word: bit 0 starts a transfer and bit 1 clears the interrupt. A write with select 3 has no effect.
- R10: `dev_ack` is high exactly in the cycles where `mem_we` is high, telling the device its word was taken.
- R11: The address counts up modulo 2^AW, so a block that starts at the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 count, 2 control, 3 unused) |
| cfg_wdata | input | AW | Register write data |
| dev_req | input | 1 | Device has a word ready on `dev_data` |
| dev_data | input | DW | Word offered by the device |
| dev_ack | output | 1 | Word taken this cycle |
| cpu_bus_busy | input | 1 | Processor owns the bus this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The hardest case to reach from the ports is a stall in the middle of a block. The engine must hold its address and count exactly across cycles where the processor holds the bus, and again across cycles where the device is not ready, and then resume at the right address. The stimulus drives the bus-busy and request lines with cyclic patterns of different periods so that both kinds of stall fall between writes. A scoreboard then demands that the written addresses stay contiguous and that the data match word for word. A start command and a base-address write are also issued while a transfer is stalled. The block must then finish the old range and use the new base only on the next start.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_CLEAR_BIT = 1;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q,
  output logic          start_cmd,
  output logic          clear_cmd
);
  cfg_sel_e sel;
  logic [AW-1:0] base_n, len_n;
  logic          base_en, len_en;
  logic          unused_ctrl_bits;

  assign sel = cfg_sel_e'(cfg_sel);

  // next-state
  always_comb begin
    base_en   = cfg_we && (sel == SEL_BASE);
    len_en    = cfg_we && (sel == SEL_LEN);
    base_n    = cfg_wdata;
    len_n     = cfg_wdata;
    start_cmd = cfg_we && (sel == SEL_CTRL) && cfg_wdata[CTRL_START_BIT];
    clear_cmd = cfg_we && (sel == SEL_CTRL) && cfg_wdata[CTRL_CLEAR_BIT];
  end

  assign unused_ctrl_bits = ^cfg_wdata[AW-1:2];

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_en) base_q <= base_n;
      if (len_en)  len_q  <= len_n;
    end
  end
endmodule

// File: rtl/dma_beat_gate.sv
module dma_beat_gate (
  input  logic xfer_active,
  input  logic dev_req,
  input  logic cpu_bus_busy,
  output logic beat
);
  // A word moves only when the bus is free, the device is ready, and a transfer runs.
  assign beat = xfer_active & dev_req & ~cpu_bus_busy;
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic          start_cmd,
  input  logic          clear_cmd,
  input  logic          beat,
  output logic          busy_q,
  output logic          irq_q,
  output logic [AW-1:0] addr_q
);
  localparam logic [AW-1:0] LAST_WORD = AW'(1);

  logic [AW-1:0] cnt_q, cnt_n, addr_n;
  logic          busy_n, irq_n, upd_en;

  // next-state
  always_comb begin
    busy_n = busy_q;
    irq_n  = irq_q;
    addr_n = addr_q;
    cnt_n  = cnt_q;
    if (clear_cmd) irq_n = 1'b0;
    if (!busy_q && start_cmd) begin
      if (len == '0) begin
        irq_n = 1'b1;
      end else begin
        busy_n = 1'b1;
        addr_n = base;
        cnt_n  = len;
      end
    end
    if (beat) begin
      addr_n = addr_q + AW'(1);
      cnt_n  = cnt_q - AW'(1);
      if (cnt_q == LAST_WORD) begin
        busy_n = 1'b0;
        irq_n  = 1'b1;
      end
    end
    upd_en = start_cmd | clear_cmd | beat;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_n;
      irq_q  <= irq_n;
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/dma_steal_engine.sv
module dma_steal_engine #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dev_req,
  input  logic [DW-1:0] dev_data,
  output logic          dev_ack,
  input  logic          cpu_bus_busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          irq
);
  logic          rst_n_sync;
  logic [AW-1:0] base_q, len_q, addr_q;
  logic          start_cmd, clear_cmd, beat, busy_q, irq_q;

  dma_rst_sync u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  dma_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .len_q(len_q),
    .start_cmd(start_cmd), .clear_cmd(clear_cmd)
  );

  dma_beat_gate u_gate (
    .xfer_active(busy_q), .dev_req(dev_req),
    .cpu_bus_busy(cpu_bus_busy), .beat(beat)
  );

  dma_xfer_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_sync), .base(base_q), .len(len_q),
    .start_cmd(start_cmd), .clear_cmd(clear_cmd), .beat(beat),
    .busy_q(busy_q), .irq_q(irq_q), .addr_q(addr_q)
  );

  assign mem_we    = beat;
  assign dev_ack   = beat;
  assign mem_addr  = addr_q;
  assign mem_wdata = dev_data;
  assign busy      = busy_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dma_steal_checker.sv
module dma_steal_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          dev_req,
  input logic [DW-1:0] dev_data,
  input logic          dev_ack,
  input logic          cpu_bus_busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          busy,
  input logic          irq
);
  logic clear_write;
  assign clear_write = cfg_we && (cfg_sel == 2'd2) && cfg_wdata[1];

  p_no_write_on_cpu_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !cpu_bus_busy);

  p_write_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && dev_req));

  p_ack_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack == mem_we);

  p_addr_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!busy || mem_addr == AW'($past(mem_addr) + 1'b1)));

  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we) |=> (busy && $stable(mem_addr)));

  p_done_sets_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear_write) |=> irq);

  p_data_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == dev_data));
endmodule

bind dma_steal_engine dma_steal_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_data(dev_data),
  .dev_ack(dev_ack), .cpu_bus_busy(cpu_bus_busy), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .irq(irq)
);

// File: tb/dma_steal_engine_bench.sv
module dma_steal_engine_bench;
  import dma_pkg::*;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 32;
  localparam int CLK_T = 10;

  logic clk, rst_n, cfg_we, dev_req, cpu_bus_busy;
  logic [1:0] cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic [DW-1:0] dev_data;
  logic dev_ack, mem_we, busy, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_checks = 0;
  int n_fail = 0;
  int widx = 0;
  logic [DW-1:0] seed = '0;
  logic [AW+DW-1:0] exp_q[$];

  dma_steal_engine #(.AW(AW), .DW(DW)) u_dma_steal_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_data(dev_data),
    .dev_ack(dev_ack), .cpu_bus_busy(cpu_bus_busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: sample late in each cycle, pop and compare expected writes.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_T/2 - 1);
      if (rst_n) begin
        if (dev_ack != mem_we)
          check(0, "R10", "dev_ack vs mem_we", 64'(dev_ack), 64'(mem_we));
        if (mem_we) begin
          check(!cpu_bus_busy, "R3", "write while cpu bus busy", 64'(cpu_bus_busy), 0);
          if (exp_q.size() == 0) begin
            check(0, "R6/R8", "unexpected write addr", 64'(mem_addr), 0);
          end else begin
            logic [AW+DW-1:0] e;
            e = exp_q.pop_front();
            check(mem_addr == e[AW+DW-1:DW], "R2", "write address",
                  64'(mem_addr), 64'(e[AW+DW-1:DW]));
            check(mem_wdata == e[DW-1:0], "R2", "write data",
                  64'(mem_wdata), 64'(e[DW-1:0]));
          end
          widx++;
        end
      end
    end
  end

  // Driver: push the expected stream for a block.
  task automatic expect_block(input logic [AW-1:0] base, input int len,
                              input logic [DW-1:0] s);
    seed = s;
    widx = 0;
    for (int i = 0; i < len; i++)
      exp_q.push_back({AW'(base + AW'(i)), DW'(s + DW'(i * 3))});
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
  endtask

  task automatic run(input int busy_mod, input int req_mod);
    for (int cyc = 0; cyc < 2000; cyc++) begin
      if (!busy) break;
      cpu_bus_busy = (busy_mod != 0) && (cyc % busy_mod == 0);
      dev_req      = (req_mod == 0) || (cyc % req_mod != 1);
      dev_data     = seed + DW'(widx * 3);
      @(negedge clk);
    end
    dev_req = 1'b0; cpu_bus_busy = 1'b0;
  endtask

  task automatic finish_checks(input string tag);
    check(busy == 1'b0, "R5", {tag, " busy low"}, 64'(busy), 0);
    check(irq == 1'b1, "R5", {tag, " irq high"}, 64'(irq), 1);
    check(exp_q.size() == 0, "R2", {tag, " words left"}, 64'(exp_q.size()), 0);
    cfg_write(SEL_CTRL, AW'(2));
    check(irq == 1'b0, "R7", {tag, " irq cleared"}, 64'(irq), 0);
  endtask

  initial begin
    #(CLK_T * 20000);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    dev_req = 1'b0; dev_data = '0; cpu_bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(busy == 0, "R1", "busy after reset", 64'(busy), 0);
    check(irq == 0, "R1", "irq after reset", 64'(irq), 0);
    check(mem_we == 0, "R1", "mem_we after reset", 64'(mem_we), 0);

    // R2/R5 plain block, device always ready, bus free
    cfg_write(SEL_BASE, AW'(16'h0010));
    cfg_write(SEL_LEN, AW'(4));
    expect_block(16'h0010, 4, 32'h1000);
    cfg_write(SEL_CTRL, AW'(1));
    check(busy == 1, "R2", "busy after start", 64'(busy), 1);
    run(0, 0);
    // R7 irq holds across idle cycles before the clear
    repeat (5) @(negedge clk);
    check(irq == 1, "R7", "irq held while idle", 64'(irq), 1);
    finish_checks("plain");

    // R3 cpu owns the bus every other cycle
    cfg_write(SEL_BASE, AW'(16'h0200));
    cfg_write(SEL_LEN, AW'(6));
    expect_block(16'h0200, 6, 32'h2000);
    cfg_write(SEL_CTRL, AW'(1));
    run(2, 0);
    finish_checks("R3 bus stalls");

    // R4 device gaps combined with bus stalls
    cfg_write(SEL_BASE, AW'(16'h0300));
    cfg_write(SEL_LEN, AW'(7));
    expect_block(16'h0300, 7, 32'h3000);
    cfg_write(SEL_CTRL, AW'(1));
    run(5, 3);
    finish_checks("R4 device gaps");

    // R6 zero length: immediate irq, no writes even with device ready
    cfg_write(SEL_LEN, AW'(0));
    cfg_write(SEL_CTRL, AW'(1));
    check(irq == 1, "R6", "irq on zero length", 64'(irq), 1);
    check(busy == 0, "R6", "busy on zero length", 64'(busy), 0);
    dev_req = 1'b1;
    repeat (4) @(negedge clk);
    dev_req = 1'b0;
    check(exp_q.size() == 0, "R6", "no words pending", 64'(exp_q.size()), 0);
    cfg_write(SEL_CTRL, AW'(2));
    check(irq == 0, "R7", "clear after zero length", 64'(irq), 0);

    // R8 start and base write during a stalled transfer
    cfg_write(SEL_BASE, AW'(16'h0040));
    cfg_write(SEL_LEN, AW'(3));
    expect_block(16'h0040, 3, 32'h4000);
    cfg_write(SEL_CTRL, AW'(1));
    cfg_write(SEL_BASE, AW'(16'h0080));
    cfg_write(SEL_CTRL, AW'(1));
    check(busy == 1, "R8", "busy kept during second start", 64'(busy), 1);
    check(mem_addr == 16'h0040, "R8", "address kept", 64'(mem_addr), 64'h40);
    run(3, 0);
    finish_checks("R8 old range");
    expect_block(16'h0080, 3, 32'h5000);
    cfg_write(SEL_CTRL, AW'(1));
    run(0, 4);
    finish_checks("R8 new base");

    // R9 select 3 writes have no effect
    cfg_write(SEL_NONE, AW'(16'hFFFF));
    check(busy == 0, "R9", "select 3 no start", 64'(busy), 0);
    check(irq == 0, "R9", "select 3 no irq", 64'(irq), 0);
    // base still 0x0080, count still 3: a start reveals the unchanged registers
    expect_block(16'h0080, 3, 32'h6000);
    cfg_write(SEL_CTRL, AW'(1));
    run(0, 0);
    finish_checks("R9 regs intact");

    // R11 address wrap
    cfg_write(SEL_BASE, AW'(16'hFFFE));
    cfg_write(SEL_LEN, AW'(4));
    expect_block(16'hFFFE, 4, 32'h7000);
    cfg_write(SEL_CTRL, AW'(1));
    run(4, 0);
    finish_checks("R11 wrap");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule